// File: doc/BRIEF.md
# Branch-Likely Resolution and Delay-Slot Annul Unit

This unit sits in the decode stage of a five-stage pipeline with one branch delay slot. It looks at the instruction in decode. It recognises the conditional branches, including the "likely" variants, and evaluates their condition on the forwarded source operands. It then chooses the next fetch address and keeps the fetch program counter.

When a likely branch is not taken, the instruction already fetched behind it in the delay slot must not run. The unit raises a registered annul flag for the cycle in which that slot instruction sits in decode. Downstream logic turns it into a bubble, with no register write and no memory access. While the flag is up, the unit also ignores the slot's own contents.

The unit also:
- asks the forwarding network for exactly the operands that the branch compares;
- for the linking forms, produces a write of the branch address plus eight to register 31;
- freezes all of its state while the pipeline is stalled.

Top module: `br_likely_unit`

## Requirements
- R1: After a synchronous reset, `fetch_pc` equals the parameter `RESET_VEC`, and `slot_annul` and `slot_in_ds` are 0.
- R2: The following encodings are branches, and every other encoding is not:
  - primary opcodes (bits 31:26) 4, 5, 6 and 7, which are ordinary EQ, NE, LEZ and GTZ;
  - primary opcodes 20, 21, 22 and 23, which are the likely EQ, NE, LEZ and GTZ;
  - opcode 1 with the sub-code in bits 20:16 equal to 0 (LTZ), 1 (GEZ), 2 (likely LTZ), 3 (likely GEZ), 16 (LTZ with link), 17 (GEZ with link), 18 (likely LTZ with link) or 19 (likely GEZ with link).

  A non-branch gives `br_taken`=0, `link_we`=0, no forwarding request, and `next_pc`=`fetch_pc`+4.
- R3: `br_taken` is evaluated as follows:
  - EQ is rs==rt, and NE is its negation;
  - LEZ and LTZ test rs as a signed value against zero;
  - GTZ is the negation of LEZ, and GEZ is the negation of LTZ.
- R4: When the branch is taken, `next_pc` is `id_pc`+4 plus the sign-extended offset in bits 15:0 shifted left by two. Otherwise `next_pc` is `fetch_pc`+4. On each non-stalled edge, `fetch_pc` loads `next_pc`.
- R5: Forwarding requests depend on the branch family:
  - Every branch asserts `fwd_rs_req`, with `fwd_rs_sel` set to bits 25:21.
  - Only the EQ/NE families (opcodes 4, 5, 20 and 21) assert `fwd_rt_req`, with `fwd_rt_sel` set to bits 20:16.
  - Both select outputs are 0 when their request is not asserted.
- R6: If a likely branch is not taken, then after the next non-stalled edge `slot_annul`=1 and `slot_in_ds`=0.
- R7: For a taken branch of any kind, or a not-taken ordinary branch, the next non-stalled edge gives `slot_in_ds`=1 and `slot_annul`=0. Any other decode content clears both flags.
- R8: The link forms (sub-codes 16 to 19) assert `link_we` whether or not they are taken, with `link_reg`=31 and `link_value`=`id_pc`+8.
- R9: While `stall`=1, `fetch_pc`, `slot_annul` and `slot_in_ds` hold their values.
- R10: While `slot_annul`=1, the decode inputs are ignored, exactly as when `id_valid`=0:
  - no branch is taken, no link is written and no forwarding is requested;
  - `next_pc` is `fetch_pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Pipeline stall; freezes fetch PC and slot flags |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_pc | input | XLEN | Address of the instruction in decode |
| rs_val | input | XLEN | Forwarded rs operand |
| rt_val | input | XLEN | Forwarded rt operand |
| fwd_rs_req | output | 1 | rs operand needed by the comparator |
| fwd_rs_sel | output | 5 | Register number for rs forwarding |
| fwd_rt_req | output | 1 | rt operand needed by the comparator |
| fwd_rt_sel | output | 5 | Register number for rt forwarding |
| br_taken | output | 1 | Branch in decode is taken |
| next_pc | output | XLEN | Address to be fetched next |
| fetch_pc | output | XLEN | Current fetch address register |
| slot_in_ds | output | 1 | Instruction now in decode executes as a delay slot |
| slot_annul | output | 1 | Instruction now in decode is a squashed bubble |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Destination of the link write |
| link_value | output | XLEN | Return address (branch address + 8) |

## Verification
The sweep crosses all sixteen branch kinds with operand pairs that sit right on each test's edge. These include:
- equal values, and zero;
- minus one, and the most negative value;
- one, and the largest positive value.

A comparator that treats operands as unsigned, or that swaps the LEZ and LTZ selection, mispredicts one of these pairs and sends `fetch_pc` to the wrong address.

Separate checks cover the following faults:
- An annul raised for an ordinary branch, or kept when a likely branch is taken, would drop a delay-slot instruction that must run.
- A link write gated by the outcome would lose r31 on a not-taken link branch.
- A stalled cycle that still updates state would skip an address.
- A slot instruction that is not ignored while annulled would let a squashed branch redirect fetch.

Every opcode and sub-code outside the branch set is also driven, to catch over-eager decoding.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam logic [5:0] OPC_REGIMM = 6'd1;

    // Decoded branch attributes carried from decode to condition/target logic
    typedef struct packed {
        logic is_br;    // instruction is a conditional branch
        logic likely;   // annul delay slot when not taken
        logic link;     // writes return address to r31
        logic cmp_eq;   // compare rs against rt (else rs against zero)
        logic lez_sel;  // zero test is "<= 0" instead of "< 0"
        logic negate;   // invert the base test
    } br_ctrl_t;

    function automatic logic [31:0] sext_off_x4(input logic [15:0] off);
        return {{14{off[15]}}, off, 2'b00};
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] subcode,
    output br_ctrl_t   ctrl
);
    always_comb begin
        ctrl = '0;
        if (opcode == OPC_REGIMM) begin
            // sub-codes 0..3 and 16..19: bit4 link, bit1 likely, bit0 negate
            if (subcode[3:2] == 2'b00) begin
                ctrl.is_br   = 1'b1;
                ctrl.link    = subcode[4];
                ctrl.likely  = subcode[1];
                ctrl.negate  = subcode[0];
                ctrl.cmp_eq  = 1'b0;
                ctrl.lez_sel = 1'b0;
            end
        end else if (opcode[5] == 1'b0 && opcode[3:2] == 2'b01) begin
            // opcodes 4..7 and 20..23: bit4 likely, bit1 zero-test, bit0 negate
            ctrl.is_br   = 1'b1;
            ctrl.likely  = opcode[4];
            ctrl.negate  = opcode[0];
            ctrl.cmp_eq  = ~opcode[1];
            ctrl.lez_sel = opcode[1];
        end
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_ctrl_t          ctrl,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic              taken
);
    logic is_neg;
    logic is_zero;
    logic base;

    always_comb begin
        is_neg  = rs_val[XLEN-1];
        is_zero = (rs_val == '0);
        if (ctrl.cmp_eq)
            base = (rs_val == rt_val);
        else if (ctrl.lez_sel)
            base = is_neg | is_zero;
        else
            base = is_neg;
        taken = ctrl.is_br & (base ^ ctrl.negate);
    end
endmodule

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] id_pc,
    input  logic [15:0]     offset,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] ret_addr
);
    localparam int EXT = XLEN - 32;
    logic [XLEN-1:0] disp;

    generate
        if (EXT > 0) begin : g_wide
            logic [31:0] d32;
            assign d32  = sext_off_x4(offset);
            assign disp = {{EXT{d32[31]}}, d32};
        end else begin : g_narrow
            logic [31:0] d32;
            assign d32  = sext_off_x4(offset);
            assign disp = d32[XLEN-1:0];
        end
    endgenerate

    assign target   = id_pc + XLEN'(4) + disp;
    assign ret_addr = id_pc + XLEN'(8);
endmodule

// File: rtl/br_likely_unit.sv
module br_likely_unit
    import br_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'hBFC0_0000)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            id_valid,
    input  logic [31:0]     id_instr,
    input  logic [XLEN-1:0] id_pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            fwd_rs_req,
    output logic [4:0]      fwd_rs_sel,
    output logic            fwd_rt_req,
    output logic [4:0]      fwd_rt_sel,
    output logic            br_taken,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] fetch_pc,
    output logic            slot_in_ds,
    output logic            slot_annul,
    output logic            link_we,
    output logic [4:0]      link_reg,
    output logic [XLEN-1:0] link_value
);
    br_ctrl_t        raw_ctrl;
    br_ctrl_t        ctrl;
    logic            br_live;
    logic            br_likely;
    logic            cond_taken;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] ret_addr;
    logic            squash_slot;

    br_decode u_dec (
        .opcode  (id_instr[31:26]),
        .subcode (id_instr[20:16]),
        .ctrl    (raw_ctrl)
    );

    // An annulled slot occupying decode is treated as empty
    assign br_live   = id_valid & ~slot_annul & raw_ctrl.is_br;
    assign br_likely = raw_ctrl.likely;

    always_comb begin
        ctrl       = raw_ctrl;
        ctrl.is_br = br_live;
    end

    br_cond #(.XLEN(XLEN)) u_cond (
        .ctrl   (ctrl),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .taken  (cond_taken)
    );

    br_target #(.XLEN(XLEN)) u_tgt (
        .id_pc    (id_pc),
        .offset   (id_instr[15:0]),
        .target   (target),
        .ret_addr (ret_addr)
    );

    assign br_taken   = cond_taken;
    assign next_pc    = cond_taken ? target : fetch_pc + XLEN'(4);

    assign fwd_rs_req = br_live;
    assign fwd_rs_sel = br_live ? id_instr[25:21] : 5'd0;
    assign fwd_rt_req = br_live & raw_ctrl.cmp_eq;
    assign fwd_rt_sel = fwd_rt_req ? id_instr[20:16] : 5'd0;

    assign link_we    = br_live & raw_ctrl.link;
    assign link_reg   = 5'd31;
    assign link_value = ret_addr;

    assign squash_slot = br_live & raw_ctrl.likely & ~cond_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc   <= RESET_VEC;
            slot_annul <= 1'b0;
            slot_in_ds <= 1'b0;
        end else if (!stall) begin
            fetch_pc   <= next_pc;
            slot_annul <= squash_slot;
            slot_in_ds <= br_live & ~squash_slot;
        end
    end
endmodule

// File: rtl/br_likely_chk.sv
module br_likely_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic            br_live,
    input logic            br_likely,
    input logic            br_taken,
    input logic            link_we,
    input logic [4:0]      link_reg,
    input logic            fwd_rs_req,
    input logic            fwd_rt_req,
    input logic [XLEN-1:0] fetch_pc,
    input logic            slot_annul,
    input logic            slot_in_ds
);
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(fetch_pc) && $stable(slot_annul) && $stable(slot_in_ds)));

    a_r6_likely_squash: assert property (@(posedge clk) disable iff (rst)
        (!stall && br_live && br_likely && !br_taken) |=> (slot_annul && !slot_in_ds));

    a_r7_ordinary_keep: assert property (@(posedge clk) disable iff (rst)
        (!stall && br_live && !br_likely) |=> (!slot_annul && slot_in_ds));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(slot_annul && slot_in_ds));

    a_r10_slot_ignored: assert property (@(posedge clk) disable iff (rst)
        slot_annul |-> (!br_taken && !link_we && !fwd_rs_req));

    a_r5_rt_needs_rs: assert property (@(posedge clk) disable iff (rst)
        fwd_rt_req |-> fwd_rs_req);

    a_r8_link_target: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_reg == 5'd31));
endmodule

bind br_likely_unit br_likely_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .br_live    (br_live),
    .br_likely  (br_likely),
    .br_taken   (br_taken),
    .link_we    (link_we),
    .link_reg   (link_reg),
    .fwd_rs_req (fwd_rs_req),
    .fwd_rt_req (fwd_rt_req),
    .fetch_pc   (fetch_pc),
    .slot_annul (slot_annul),
    .slot_in_ds (slot_in_ds)
);

// File: tb/test_br_likely_unit.sv
module test_br_likely_unit;
    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        id_valid = 1'b0;
    logic [31:0] id_instr = '0;
    logic [31:0] id_pc = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        fwd_rs_req, fwd_rt_req, br_taken, slot_in_ds, slot_annul, link_we;
    logic [4:0]  fwd_rs_sel, fwd_rt_sel, link_reg;
    logic [31:0] next_pc, fetch_pc, link_value;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] exp_fpc;
    logic        exp_annul;
    logic        exp_ds;

    br_likely_unit #(.XLEN(32), .RESET_VEC(RV)) i_br_likely_unit (
        .clk(clk), .rst(rst), .stall(stall), .id_valid(id_valid),
        .id_instr(id_instr), .id_pc(id_pc), .rs_val(rs_val), .rt_val(rt_val),
        .fwd_rs_req(fwd_rs_req), .fwd_rs_sel(fwd_rs_sel),
        .fwd_rt_req(fwd_rt_req), .fwd_rt_sel(fwd_rt_sel),
        .br_taken(br_taken), .next_pc(next_pc), .fetch_pc(fetch_pc),
        .slot_in_ds(slot_in_ds), .slot_annul(slot_annul),
        .link_we(link_we), .link_reg(link_reg), .link_value(link_value)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference semantics written per mnemonic
    function automatic void ref_eval(input logic [31:0] ins, input logic [31:0] a,
                                     input logic [31:0] b, output bit isb, output bit lk,
                                     output bit lnk, output bit urt, output bit tk);
        int sa;
        sa  = signed'(a);
        isb = 1; lk = 0; lnk = 0; urt = 0; tk = 0;
        case (ins[31:26])
            6'd4:  begin urt = 1; tk = (a == b); end
            6'd5:  begin urt = 1; tk = (a != b); end
            6'd6:  tk = (sa <= 0);
            6'd7:  tk = (sa > 0);
            6'd20: begin urt = 1; lk = 1; tk = (a == b); end
            6'd21: begin urt = 1; lk = 1; tk = (a != b); end
            6'd22: begin lk = 1; tk = (sa <= 0); end
            6'd23: begin lk = 1; tk = (sa > 0); end
            6'd1: begin
                case (ins[20:16])
                    5'd0:  tk = (sa < 0);
                    5'd1:  tk = (sa >= 0);
                    5'd2:  begin lk = 1; tk = (sa < 0); end
                    5'd3:  begin lk = 1; tk = (sa >= 0); end
                    5'd16: begin lnk = 1; tk = (sa < 0); end
                    5'd17: begin lnk = 1; tk = (sa >= 0); end
                    5'd18: begin lnk = 1; lk = 1; tk = (sa < 0); end
                    5'd19: begin lnk = 1; lk = 1; tk = (sa >= 0); end
                    default: isb = 0;
                endcase
            end
            default: isb = 0;
        endcase
    endfunction

    // One cycle: drive just after a falling edge, check combinational outputs,
    // then check registered state at the next falling edge.
    task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                        input logic [31:0] a, input logic [31:0] b, input logic stl);
        bit isb, lk, lnk, urt, tk, live, ignored;
        logic [31:0] exp_next;
        string rc, rr;
        id_valid = v; id_instr = ins; id_pc = pc; rs_val = a; rt_val = b; stall = stl;
        #1;
        ref_eval(ins, a, b, isb, lk, lnk, urt, tk);
        ignored = v && exp_annul;
        live    = v && !exp_annul && isb;
        if (!live) begin lk = 0; lnk = 0; urt = 0; tk = 0; end
        exp_next = tk ? (pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00}) : exp_fpc + 32'd4;
        rc = ignored ? "R10" : (isb ? "R3" : "R2");
        chk(rc, {31'd0, br_taken}, {31'd0, tk});
        chk(ignored ? "R10" : "R4", next_pc, exp_next);
        chk(ignored ? "R10" : "R5", {fwd_rs_req, fwd_rs_sel, fwd_rt_req, fwd_rt_sel},
            {live, live ? ins[25:21] : 5'd0, urt, urt ? ins[20:16] : 5'd0});
        chk(ignored ? "R10" : "R8", {31'd0, link_we}, {31'd0, lnk});
        if (lnk) begin
            chk("R8", link_value, pc + 32'd8);
            chk("R8", {27'd0, link_reg}, 32'd31);
        end
        @(negedge clk);
        if (!stl) begin
            exp_fpc   = exp_next;
            exp_annul = live && lk && !tk;
            exp_ds    = live && !(lk && !tk);
        end
        rr = stl ? "R9" : (exp_annul ? "R6" : "R7");
        chk(stl ? "R9" : "R4", fetch_pc, exp_fpc);
        chk(rr, {30'd0, slot_annul, slot_in_ds}, {30'd0, exp_annul, exp_ds});
    endtask

    logic [31:0] av [8] = '{32'd0, 32'd5, 32'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFD,
                            32'd1, 32'h8000_0000, 32'h7FFF_FFFF};
    logic [31:0] bv [8] = '{32'd0, 32'd5, 32'd6, 32'hFFFF_FFFF, 32'd2,
                            32'd0, 32'd0, 32'h8000_0000};

    initial begin
        exp_fpc = RV; exp_annul = 0; exp_ds = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", fetch_pc, RV);
        chk("R1", {30'd0, slot_annul, slot_in_ds}, 32'd0);

        // Sweep all branch kinds against boundary operand pairs
        for (int k = 0; k < 16; k++) begin
            for (int p = 0; p < 8; p++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [5:0]  op;
                    logic [4:0]  sub;
                    logic [15:0] off;
                    if (k < 4)      begin op = 6'(4 + k);  sub = 5'd9; end
                    else if (k < 8) begin op = 6'(16 + k); sub = 5'd9; end
                    else begin
                        op  = 6'd1;
                        sub = (k < 12) ? 5'(k - 8) : 5'(k + 4);
                    end
                    off = o ? 16'hFFF8 : 16'h0010;
                    step(1'b0, '0, '0, '0, '0, 1'b0);
                    step(1'b1, {op, 5'd7, sub, off}, 32'h0040_1000 + 32'(k * 64 + p * 4),
                         av[p], bv[p], 1'b0);
                end
            end
        end

        // Opcodes outside the branch set (R2)
        for (int op = 0; op < 64; op++) begin
            if (!(op == 1 || (op >= 4 && op <= 7) || (op >= 20 && op <= 23)))
                step(1'b1, {6'(op), 5'd3, 5'd4, 16'h0020}, 32'h0000_2000, 32'd0, 32'd0, 1'b0);
        end
        for (int s = 0; s < 32; s++) begin
            if (!(s <= 3 || (s >= 16 && s <= 19)))
                step(1'b1, {6'd1, 5'd3, 5'(s), 16'h0020}, 32'h0000_3000, 32'hFFFF_FFFF,
                     32'd0, 1'b0);
        end

        // R9: stall holds while a taken likely branch sits in decode
        step(1'b0, '0, '0, '0, '0, 1'b0);
        step(1'b1, {6'd20, 5'd1, 5'd2, 16'h0040}, 32'h0000_5000, 32'd9, 32'd9, 1'b1);
        step(1'b1, {6'd20, 5'd1, 5'd2, 16'h0040}, 32'h0000_5000, 32'd9, 32'd9, 1'b1);
        step(1'b1, {6'd20, 5'd1, 5'd2, 16'h0040}, 32'h0000_5000, 32'd9, 32'd9, 1'b0);
        // R9: stall holds an annul flag
        step(1'b1, {6'd21, 5'd1, 5'd2, 16'h0040}, 32'h0000_6000, 32'd9, 32'd9, 1'b0);
        step(1'b1, {6'd4, 5'd1, 5'd2, 16'h0100}, 32'h0000_6004, 32'd1, 32'd1, 1'b1);

        // R10: a branch sitting in an annulled slot is ignored
        step(1'b1, {6'd4, 5'd1, 5'd2, 16'h0100}, 32'h0000_6004, 32'd1, 32'd1, 1'b0);
        step(1'b1, {6'd1, 5'd1, 5'd18, 16'h0008}, 32'h0000_7000, 32'd3, 32'd0, 1'b0);
        step(1'b1, {6'd1, 5'd1, 5'd17, 16'h0008}, 32'h0000_7004, 32'd3, 32'd0, 1'b0);
        step(1'b0, '0, '0, '0, '0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule